// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into an internal circular RAM. Once armed it keeps overwriting the oldest entries, so at any moment the RAM holds the most recent history. When the trigger input is seen, a host-loaded post-trigger count starts to run down by one for every word stored. When the count reaches zero, writing stops. The RAM then holds both the words leading up to the event and a chosen number of words after it.

A host reaches the block through a small register port with a 4-bit word address, write and read strobes, and 32-bit write and read data. The port has nine registers. The host prepares a capture by clearing the write pointer, loading the post-trigger count and setting the enable bit. It then polls the status word. The full flag tells it whether the entry at the write pointer is the oldest valid one, or whether only entries from 0 up to the write pointer minus one hold data. The host moves the read pointer to the first valid entry and pulls the words out through the data register, which steps the pointer on every read.

Capture is driven by a state machine with five states. IDLE means disabled. ARMED stores words and waits for the trigger. POST stores words and counts down. DRAIN is a single cycle in which the last accepted word is written. DONE means stopped with acquisition complete. The transitions are:
- arm: a control write with enable set moves any state to ARMED.
- stop: a control write with enable clear moves any state to IDLE.
- trigger: in ARMED, the trigger input moves the machine to POST, or straight to DRAIN when the count is already zero.
- last-word: in POST, accepting the word that takes the count from one to zero, or finding the count at zero, moves the machine to DRAIN.
- drained: DRAIN always moves to DONE.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the read pointer, write pointer, control and post-trigger count read 0, the read data output is 0, and status reads 0x8 (only the formatter-empty bit set).
- R2: Address 0 returns the fixed identification value 0x7C0B0001. Address 1 returns the RAM depth in words (16 by default). Address 2 returns the word width (32). Writes to these three addresses change nothing.
- R3: A read of address 4 returns the RAM entry at the read pointer and advances the read pointer by one. Reads of any other address leave the read pointer unchanged.
- R4: The read pointer (address 5) and write pointer (address 6) are writable and keep only the written value modulo the depth. Each stored word goes to the write pointer, which then advances by one and wraps from depth-1 to 0. The read pointer also wraps while advancing.
- R5: Status bit 0 (full) sets when the write pointer wraps from depth-1 to 0 on a stored word. A host write to the write pointer clears it.
- R6: While armed and waiting, the trigger input sets status bit 1 (triggered). After that, each stored word decrements the post-trigger count (address 7). A word arriving in the same cycle as the trigger counts as pre-trigger.
- R7: When the post-trigger count reaches zero, no further words are stored and status bit 2 (acquisition complete) sets. The RAM then holds exactly the pre-trigger words plus the loaded count of post-trigger words.
- R8: Status bit 3 (formatter empty) is low in the cycle after a word is accepted, while that word is still pending, and high once it has been written to the RAM.
- R9: Control (address 8) bit 0 enables capture and bit 1 selects the demultiplexed port mode. Both bits read back. Writing 0 stops capture, and words presented while capture is stopped or complete are not stored.
- R10: A trigger that arrives when the post-trigger count is 0 ends acquisition at once: status bit 2 sets and no word after the trigger is stored.
- R11: Reads of unused addresses 9 to 15 return 0.
- R12: A control write with bit 0 set re-arms capture and clears the triggered and acquisition-complete flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_valid | input | 1 | A trace word is presented this cycle |
| trc_word | input | 32 | Trace word |
| trig_in | input | 1 | Trigger event |
| reg_sel | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, held until the next read |

## Verification
The hardest state to reach from the ports is the one-cycle window in which a word has been accepted but not yet written. Only there does the formatter-empty bit read low. The bench reaches it by presenting a word and, in the very next cycle, issuing a status read, so that the read is registered while the word is still pending. A second hard case is the wrapped buffer, where the oldest entry sits at the write pointer. To reach it, the bench streams more pre-trigger words than the depth and then drains the whole RAM from the write pointer onward. The expected sequence is computed from the stream indices modulo the depth.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;
    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] ADR_IDENT  = 4'd0;
    localparam logic [SEL_W-1:0] ADR_DEPTH  = 4'd1;
    localparam logic [SEL_W-1:0] ADR_WIDTH  = 4'd2;
    localparam logic [SEL_W-1:0] ADR_STATUS = 4'd3;
    localparam logic [SEL_W-1:0] ADR_DATA   = 4'd4;
    localparam logic [SEL_W-1:0] ADR_RDPTR  = 4'd5;
    localparam logic [SEL_W-1:0] ADR_WRPTR  = 4'd6;
    localparam logic [SEL_W-1:0] ADR_TRGCNT = 4'd7;
    localparam logic [SEL_W-1:0] ADR_CTRL   = 4'd8;

    localparam int STS_FULL  = 0;
    localparam int STS_TRIG  = 1;
    localparam int STS_ACQ   = 2;
    localparam int STS_EMPTY = 3;

    localparam int CTL_EN    = 0;
    localparam int CTL_DEMUX = 1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_POST  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } cap_state_e;
endpackage

// File: rtl/trace_cap_fsm.sv
module trace_cap_fsm
    import trace_cap_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             stop,
    input  logic             trig_in,
    input  logic             trc_valid,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic             accept,
    output logic [CNT_W-1:0] cnt_q,
    output logic             trig_flag,
    output logic             acq_flag
);
    cap_state_e state_q, state_d;
    logic       cnt_zero, cnt_one, post_step, enter_drain, trig_seen;

    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = ST_IDLE;
        end else if (arm) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (trig_in) state_d = cnt_zero ? ST_DRAIN : ST_POST;
                ST_POST:  if (cnt_zero || (trc_valid && cnt_one)) state_d = ST_DRAIN;
                ST_DRAIN: state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        accept    = 1'b0;
        post_step = 1'b0;
        trig_seen = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                accept    = trc_valid;
                trig_seen = trig_in && !arm && !stop;
            end
            ST_POST: begin
                accept    = trc_valid && !cnt_zero;
                post_step = trc_valid && !cnt_zero;
            end
            default: ;
        endcase
    end

    assign enter_drain = (state_q != ST_DRAIN) && (state_d == ST_DRAIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            trig_flag <= 1'b0;
            acq_flag  <= 1'b0;
        end else begin
            if (cnt_wr)         cnt_q <= cnt_wdata;
            else if (post_step) cnt_q <= cnt_q - 1'b1;
            if (arm)            trig_flag <= 1'b0;
            else if (trig_seen) trig_flag <= 1'b1;
            if (arm)              acq_flag <= 1'b0;
            else if (enter_drain) acq_flag <= 1'b1;
        end
    end

    // R6: a trigger seen while waiting raises the triggered flag
    assert_trig_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && trig_in && !arm && !stop) |=> trig_flag);

    // R6: every post-trigger word stored lowers the count by one
    assert_count_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST && accept && !cnt_wr) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    // R7: with acquisition complete no word is accepted
    assert_no_store_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_flag && !arm) |-> !accept);

    // R12: arming clears both capture flags
    assert_arm_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!trig_flag && !acq_flag));
endmodule

// File: rtl/trace_cap_store.sv
module trace_cap_store #(
    parameter int DEPTH_LOG2 = 4,
    parameter int WORD_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic [WORD_W-1:0]     trc_word,
    input  logic                  wp_wr,
    input  logic                  rp_wr,
    input  logic [DEPTH_LOG2-1:0] ptr_wdata,
    input  logic                  rd_adv,
    output logic [DEPTH_LOG2-1:0] wp_q,
    output logic [DEPTH_LOG2-1:0] rp_q,
    output logic                  full_q,
    output logic                  pend_q,
    output logic [WORD_W-1:0]     rd_word
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2-1:0] LAST = DEPTH_LOG2'(DEPTH - 1);

    logic [WORD_W-1:0] ram [DEPTH];
    logic [WORD_W-1:0] pend_word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_word_q <= '0;
        end else begin
            pend_q      <= accept;
            pend_word_q <= trc_word;
        end
    end

    always_ff @(posedge clk) begin
        if (pend_q) ram[wp_q] <= pend_word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q   <= '0;
            full_q <= 1'b0;
        end else if (wp_wr) begin
            wp_q   <= ptr_wdata;
            full_q <= 1'b0;
        end else if (pend_q) begin
            wp_q <= wp_q + 1'b1;
            if (wp_q == LAST) full_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rp_q <= '0;
        else if (rp_wr)  rp_q <= ptr_wdata;
        else if (rd_adv) rp_q <= rp_q + 1'b1;
    end

    assign rd_word = ram[rp_q];

    // R4: with nothing pending and no host write the write pointer holds
    assert_wp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !wp_wr) |=> $stable(wp_q));

    // R5: wrapping the write pointer raises the full flag
    assert_full_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !wp_wr && wp_q == LAST) |=> (full_q && wp_q == '0));

    // R3: a data read moves the read pointer on by one
    assert_rp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && !rp_wr) |=> (rp_q == DEPTH_LOG2'($past(rp_q) + 1'b1)));
endmodule

// File: rtl/trace_cap_regs.sv
module trace_cap_regs
    import trace_cap_pkg::*;
#(
    parameter int          DEPTH_LOG2 = 4,
    parameter int          WORD_W     = 32,
    parameter int          CNT_W      = 5,
    parameter logic [31:0] ID_VALUE   = 32'h7C0B_0001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [1:0]            ctl_wdata,
    input  logic                  full,
    input  logic                  trig_flag,
    input  logic                  acq_flag,
    input  logic                  pend,
    input  logic [DEPTH_LOG2-1:0] rp,
    input  logic [DEPTH_LOG2-1:0] wp,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [WORD_W-1:0]     rd_word,
    output logic                  arm,
    output logic                  stop,
    output logic                  wp_wr,
    output logic                  rp_wr,
    output logic                  cnt_wr,
    output logic                  rd_adv,
    output logic [WORD_W-1:0]     reg_rdata
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [1:0]        ctrl_q;
    logic [WORD_W-1:0] rd_mux, status_w;
    logic              ctl_wr;

    assign ctl_wr = reg_wr && (reg_sel == ADR_CTRL);
    assign arm    = ctl_wr && ctl_wdata[CTL_EN];
    assign stop   = ctl_wr && !ctl_wdata[CTL_EN];
    assign wp_wr  = reg_wr && (reg_sel == ADR_WRPTR);
    assign rp_wr  = reg_wr && (reg_sel == ADR_RDPTR);
    assign cnt_wr = reg_wr && (reg_sel == ADR_TRGCNT);
    assign rd_adv = reg_rd && (reg_sel == ADR_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= 2'b00;
        else if (ctl_wr) ctrl_q <= ctl_wdata;
    end

    always_comb begin
        status_w            = '0;
        status_w[STS_FULL]  = full;
        status_w[STS_TRIG]  = trig_flag;
        status_w[STS_ACQ]   = acq_flag;
        status_w[STS_EMPTY] = !pend;
    end

    always_comb begin
        unique case (reg_sel)
            ADR_IDENT:  rd_mux = WORD_W'(ID_VALUE);
            ADR_DEPTH:  rd_mux = WORD_W'(DEPTH);
            ADR_WIDTH:  rd_mux = WORD_W'(WORD_W);
            ADR_STATUS: rd_mux = status_w;
            ADR_DATA:   rd_mux = rd_word;
            ADR_RDPTR:  rd_mux = WORD_W'(rp);
            ADR_WRPTR:  rd_mux = WORD_W'(wp);
            ADR_TRGCNT: rd_mux = WORD_W'(cnt);
            ADR_CTRL:   rd_mux = WORD_W'(ctrl_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R2: identification read returns the constant
    assert_ident_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == ADR_IDENT) |=> (reg_rdata == WORD_W'(ID_VALUE)));

    // R11: unused addresses read as zero
    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel > ADR_CTRL) |=> (reg_rdata == '0));

    // R9: a control write of zero leaves enable clear
    assert_stop_clears_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !ctrl_q[CTL_EN]);
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import trace_cap_pkg::*;
#(
    parameter int          DEPTH_LOG2 = 4,
    parameter int          WORD_W     = 32,
    parameter logic [31:0] ID_VALUE   = 32'h7C0B_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trc_valid,
    input  logic [WORD_W-1:0] trc_word,
    input  logic              trig_in,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam int CNT_W = DEPTH_LOG2 + 1;

    logic                  accept, trig_flag, acq_flag, full, pend;
    logic                  arm, stop, wp_wr, rp_wr, cnt_wr, rd_adv;
    logic [CNT_W-1:0]      cnt;
    logic [DEPTH_LOG2-1:0] wp, rp;
    logic [WORD_W-1:0]     rd_word;
    logic                  unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[WORD_W-1:CNT_W];

    trace_cap_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .trig_in(trig_in),
        .trc_valid(trc_valid), .cnt_wr(cnt_wr), .cnt_wdata(reg_wdata[CNT_W-1:0]),
        .accept(accept), .cnt_q(cnt), .trig_flag(trig_flag), .acq_flag(acq_flag)
    );

    trace_cap_store #(.DEPTH_LOG2(DEPTH_LOG2), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .accept(accept), .trc_word(trc_word),
        .wp_wr(wp_wr), .rp_wr(rp_wr), .ptr_wdata(reg_wdata[DEPTH_LOG2-1:0]),
        .rd_adv(rd_adv), .wp_q(wp), .rp_q(rp), .full_q(full), .pend_q(pend),
        .rd_word(rd_word)
    );

    trace_cap_regs #(
        .DEPTH_LOG2(DEPTH_LOG2), .WORD_W(WORD_W), .CNT_W(CNT_W), .ID_VALUE(ID_VALUE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .ctl_wdata(reg_wdata[1:0]), .full(full), .trig_flag(trig_flag),
        .acq_flag(acq_flag), .pend(pend), .rp(rp), .wp(wp), .cnt(cnt),
        .rd_word(rd_word), .arm(arm), .stop(stop), .wp_wr(wp_wr), .rp_wr(rp_wr),
        .cnt_wr(cnt_wr), .rd_adv(rd_adv), .reg_rdata(reg_rdata)
    );

    // R8: a word accepted in one cycle is pending in the next
    assert_pending_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pend);
endmodule

// File: tb/trace_capture_buf_bench.sv
module trace_capture_buf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trc_valid = 1'b0;
    logic [31:0] trc_word = '0;
    logic        trig_in = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_capture_buf u_trace_capture_buf (
        .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_word(trc_word),
        .trig_in(trig_in), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_sel = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic push(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); trc_valid = 1'b1; trc_word = base + 32'(i);
        end
        @(negedge clk); trc_valid = 1'b0;
    endtask

    task automatic trigger();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic arm_capture(input logic [31:0] count);
        wr(4'd6, 32'd0);
        wr(4'd7, count);
        wr(4'd8, 32'd1);
    endtask

    function automatic logic [31:0] seq_a(input int k);
        return (k < 5) ? 32'h100 + 32'(k) : 32'h200 + 32'(k - 5);
    endfunction

    function automatic logic [31:0] seq_b(input int j);
        return (j < 20) ? 32'h300 + 32'(j) : 32'h400 + 32'(j - 20);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'd0);
        rd(4'd3, v); chk("R1 status", v, 32'h8);
        rd(4'd5, v); chk("R1 rdptr", v, 32'd0);
        rd(4'd6, v); chk("R1 wrptr", v, 32'd0);
        rd(4'd7, v); chk("R1 count", v, 32'd0);
        rd(4'd8, v); chk("R1 ctrl", v, 32'd0);

        // R2 constant registers, writes ignored
        for (int pass = 0; pass < 2; pass++) begin
            rd(4'd0, v); chk("R2 ident", v, 32'h7C0B_0001);
            rd(4'd1, v); chk("R2 depth", v, 32'(DEPTH));
            rd(4'd2, v); chk("R2 width", v, 32'd32);
            wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'h5); wr(4'd2, 32'h7);
        end

        // R11 unused addresses
        for (int a = 9; a < 16; a++) begin
            rd(4'(a), v); chk("R11 unused", v, 32'd0);
        end

        // R4 pointer writes wrap modulo depth
        wr(4'd5, 32'h13); rd(4'd5, v); chk("R4 rdptr mod", v, 32'd3);
        wr(4'd6, 32'h2A); rd(4'd6, v); chk("R4 wrptr mod", v, 32'd10);

        // R8 formatter-empty low while a word is pending
        arm_capture(32'd4);
        @(negedge clk); trc_valid = 1'b1; trc_word = 32'hABC;
        @(negedge clk); trc_valid = 1'b0; reg_sel = 4'd3; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        chk("R8 pending status", reg_rdata, 32'h0);
        rd(4'd3, v); chk("R8 drained status", v, 32'h8);
        rd(4'd6, v); chk("R8 word stored", v, 32'd1);
        wr(4'd8, 32'd0);

        // R6 R7 capture without wrap, count 3
        arm_capture(32'd3);
        push(5, 32'h100);
        trigger();
        rd(4'd3, v); chk("R6 triggered", v, 32'h2 | 32'h8);
        push(10, 32'h200);
        repeat (3) @(negedge clk);
        rd(4'd3, v); chk("R7 status done", v, 32'hE);
        rd(4'd6, v); chk("R7 stored words", v, 32'd8);
        rd(4'd7, v); chk("R6 count zero", v, 32'd0);
        wr(4'd5, 32'd0);
        for (int k = 0; k < 8; k++) begin
            rd(4'd4, v); chk("R3 data no-wrap", v, seq_a(k));
            if (k == 3) begin
                rd(4'd3, v); rd(4'd6, v); rd(4'd5, v);
                chk("R3 other reads keep rdptr", v, 32'd4);
            end
        end
        rd(4'd5, v); chk("R3 rdptr advanced", v, 32'd8);

        // R9 words after completion ignored
        push(4, 32'h900);
        rd(4'd6, v); chk("R9 done ignores words", v, 32'd8);

        // R12 re-arm clears flags
        wr(4'd8, 32'd1);
        rd(4'd3, v); chk("R12 rearm clears", v, 32'h8);
        wr(4'd8, 32'd0);

        // R5 wrap: 20 pre words, count 4
        arm_capture(32'd4);
        push(20, 32'h300);
        rd(4'd3, v); chk("R5 full set", v, 32'h9);
        trigger();
        push(10, 32'h400);
        repeat (3) @(negedge clk);
        rd(4'd3, v); chk("R5 status wrapped done", v, 32'hF);
        rd(4'd6, v); chk("R4 wrptr wrapped", v, 32'd8);
        wr(4'd5, 32'd8);
        for (int k = 0; k < DEPTH; k++) begin
            rd(4'd4, v); chk("R3 data wrapped", v, seq_b(8 + k));
        end
        rd(4'd5, v); chk("R4 rdptr wrap", v, 32'd8);
        wr(4'd6, 32'd0);
        rd(4'd3, v); chk("R5 full cleared", v, 32'hE);

        // R9 stop mid capture, demux bit
        wr(4'd7, 32'd5);
        wr(4'd8, 32'd3);
        rd(4'd8, v); chk("R9 ctrl readback", v, 32'd3);
        push(3, 32'h500);
        wr(4'd8, 32'd0);
        push(4, 32'h600);
        rd(4'd6, v); chk("R9 stop halts store", v, 32'd3);
        rd(4'd3, v); chk("R9 stop status", v, 32'h8);
        trigger();
        rd(4'd3, v); chk("R9 trigger ignored when stopped", v, 32'h8);

        // R10 trigger with zero count
        arm_capture(32'd0);
        push(2, 32'h700);
        trigger();
        push(3, 32'h800);
        repeat (2) @(negedge clk);
        rd(4'd6, v); chk("R10 no post words", v, 32'd2);
        rd(4'd3, v); chk("R10 status", v, 32'hE);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule